// File: doc/BRIEF.md
# Video Link Receive Deframer

This block sits behind the symbol decoder of a serial video receiver. Each cycle of the recovered pixel clock it takes one decoded link word. The word carries two byte slots, a control flag per slot and a decode-error flag per slot. From these it rebuilds a 16-bit pixel bus with its data-enable, horizontal sync and vertical sync. A line-start control word in slot 0 re-establishes lock on every line, so a receiver that is plugged in or disturbed in mid-stream recovers at the next line without outside help. The line-start word also carries the vertical sync level in bit 0 of slot 1.

While vertical sync is asserted, words that carry the side-channel control character in slot 0 deliver their slot 1 byte on a separate strobed output and do not appear as video. A link-good output reports whether clean symbols are arriving. A configuration pin sets the sync polarity. A second pin chooses whether the outputs change on the rising or the falling edge of the recovered clock.

Top module: `rx_deframer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block clears `link_ok_o`, `de_o`, `aux_valid_o`, `pix_o` and `aux_data_o`, and drives both syncs to their inactive level.
- R2: A line-start word (slot 0 = 0xBC with `sym_k_i` = 2'b01 and no error flag) sets `link_ok_o` to 1 from that word's output cycle. It stays 1 until an error word arrives.
- R3: A word is bad if any `sym_err_i` bit is set, if `sym_k_i[1]` is set, or if `sym_k_i[0]` is set and slot 0 is not one of 0xBC, 0x1C or 0xFB. A bad word clears `link_ok_o` and clears the stored vertical level. Until the next line-start word, `de_o`, `aux_valid_o` and `pix_o` stay 0 and both syncs stay inactive.
- R4: While locked, a word with `sym_k_i` = 2'b00 appears as `pix_o` = `sym_data_i` (slot 1 in bits 15:8) with `de_o` = 1.
- R5: While locked, horizontal sync is active in the output cycle of a line-start word and in the next three output cycles. A new line-start word restarts this count.
- R6: While locked, vertical sync is active exactly when bit 8 of the latest line-start word was 1.
- R7: While locked and while the stored vertical level is 1, a word with slot 0 = 0xFB and `sym_k_i[0]` = 1 gives a one-cycle `aux_valid_o` with `aux_data_o` = slot 1 and `de_o` = 0. When the stored vertical level is 0, or when unlocked, such a word gives no strobe.
- R8: `sync_low_i` = 1 makes both syncs active low. With 0 they are active high.
- R9: With `fall_edge_i` = 0, the outputs for a word sampled at a rising edge change at that same rising edge. With 1, they change at the following falling edge.
- R10: While locked, the idle control word (slot 0 = 0x1C with `sym_k_i[0]` = 1) gives `de_o` = 0, `pix_o` = 0 and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_data_i | input | 16 | Decoded word: slot 1 in bits 15:8, slot 0 in bits 7:0 |
| sym_k_i | input | 2 | Control-character flag per slot |
| sym_err_i | input | 2 | Decode-error flag per slot |
| sync_low_i | input | 1 | 1 = active-low syncs, 0 = active-high |
| fall_edge_i | input | 1 | 1 = outputs update on falling edge |
| pix_o | output | 16 | Recovered pixel |
| de_o | output | 1 | Active-video enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| link_ok_o | output | 1 | Clean symbols being received |
| aux_valid_o | output | 1 | Side-channel byte strobe |
| aux_data_o | output | 8 | Side-channel byte |

## Verification
The horizontal-sync window and the side-channel strobe can fall in the same output cycle. The bench provokes this by sending a side-channel word right after a line-start word that raises vertical sync, and it expects the sync to stay active while the strobe fires with DE low. A decode error that lands inside the sync window is a second overlap. The bench expects the sync to be cut at once, with lock lost in the same cycle. A reference model in the bench predicts every output on every clock, and it also samples shortly after each rising edge to tell the two output-edge modes apart.

// File: rtl/rx_deframer_pkg.sv
// Shared constants and types for the receive deframer.
package rx_deframer_pkg;
    localparam int BYTE_W = 8;
    localparam int SLOTS  = 2;
    localparam int PIX_W  = BYTE_W * SLOTS;

    localparam logic [BYTE_W-1:0] CODE_LINE = 8'hBC;
    localparam logic [BYTE_W-1:0] CODE_IDLE = 8'h1C;
    localparam logic [BYTE_W-1:0] CODE_AUX  = 8'hFB;

    typedef enum logic [2:0] {
        WK_VIDEO,
        WK_LINE,
        WK_AUX,
        WK_IDLE,
        WK_BAD
    } word_kind_e;

    typedef struct packed {
        logic              link_ok;
        logic              de;
        logic              hs_act;
        logic              vs_act;
        logic              aux_vld;
        logic [PIX_W-1:0]  pix;
        logic [BYTE_W-1:0] aux;
    } rx_view_t;
endpackage

// File: rtl/rx_sym_classify.sv
// Classifies one decoded link word. Purely combinational.
// Assumes slot 0 alone may carry a control character; any error flag
// or a control flag in a later slot makes the word bad.
module rx_sym_classify
    import rx_deframer_pkg::*;
(
    input  logic [BYTE_W-1:0] lead_i,
    input  logic [SLOTS-1:0]  k_i,
    input  logic [SLOTS-1:0]  err_i,
    output word_kind_e        kind_o
);
    logic [SLOTS-1:0] slot_bad;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            if (s == 0) begin : g_lead
                assign slot_bad[s] = err_i[s];
            end else begin : g_tail
                assign slot_bad[s] = err_i[s] | k_i[s];
            end
        end
    endgenerate

    // Decide the word kind from flags and the slot-0 control code.
    always_comb begin
        if (|slot_bad) begin
            kind_o = WK_BAD;
        end else if (!k_i[0]) begin
            kind_o = WK_VIDEO;
        end else begin
            case (lead_i)
                CODE_LINE: kind_o = WK_LINE;
                CODE_IDLE: kind_o = WK_IDLE;
                CODE_AUX:  kind_o = WK_AUX;
                default:   kind_o = WK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/rx_link_tracker.sv
// Tracks lock, the horizontal-sync window and the stored vertical level.
// Produces one registered output view per rising clock edge.
// Assumes one word per clock and a synchronous active-low reset.
module rx_link_tracker
    import rx_deframer_pkg::*;
#(
    parameter int HS_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  word_kind_e       kind_i,
    input  logic [PIX_W-1:0] data_i,
    output rx_view_t         view_o
);
    localparam int CNT_W = $clog2(HS_LEN + 1);

    logic             locked, nxt_lock;
    logic             vs_lvl, nxt_vs;
    logic [CNT_W-1:0] hs_left, nxt_left;
    logic             hs_now;
    rx_view_t         nxt_view;

    // Next-state and next-output computation for the current word.
    always_comb begin
        nxt_lock = locked;
        nxt_vs   = vs_lvl;
        hs_now   = (hs_left != '0);
        nxt_left = hs_now ? hs_left - CNT_W'(1) : '0;
        nxt_view = '0;
        case (kind_i)
            WK_BAD: begin
                nxt_lock = 1'b0;
                nxt_vs   = 1'b0;
                nxt_left = '0;
                hs_now   = 1'b0;
            end
            WK_LINE: begin
                nxt_lock = 1'b1;
                nxt_vs   = data_i[BYTE_W];
                nxt_left = CNT_W'(HS_LEN - 1);
                hs_now   = 1'b1;
            end
            WK_VIDEO: begin
                if (locked) begin
                    nxt_view.de  = 1'b1;
                    nxt_view.pix = data_i;
                end
            end
            WK_AUX: begin
                if (locked && vs_lvl) begin
                    nxt_view.aux_vld = 1'b1;
                    nxt_view.aux     = data_i[PIX_W-1:BYTE_W];
                end
            end
            default: ;
        endcase
        nxt_view.link_ok = nxt_lock;
        nxt_view.hs_act  = hs_now & nxt_lock;
        nxt_view.vs_act  = nxt_vs & nxt_lock;
    end

    // Register tracking state and the output view.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked  <= 1'b0;
            vs_lvl  <= 1'b0;
            hs_left <= '0;
            view_o  <= '0;
        end else begin
            locked  <= nxt_lock;
            vs_lvl  <= nxt_vs;
            hs_left <= nxt_left;
            view_o  <= nxt_view;
        end
    end
endmodule

// File: rtl/rx_out_stage.sv
// Selects the clock edge on which the output view appears.
// Assumes fall_i is a static configuration level.
module rx_out_stage
    import rx_deframer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fall_i,
    input  rx_view_t view_i,
    output rx_view_t view_o
);
    rx_view_t neg_q;

    // Retime the rising-edge view onto the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            neg_q <= '0;
        end else begin
            neg_q <= view_i;
        end
    end

    assign view_o = fall_i ? neg_q : view_i;
endmodule

// File: rtl/rx_deframer.sv
// Receive deframer top: classifies link words, tracks lock and syncs,
// selects the output edge and applies sync polarity.
// Assumes decoded words arrive one per recovered clock.
module rx_deframer
    import rx_deframer_pkg::*;
#(
    parameter int HS_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] sym_data_i,
    input  logic [SLOTS-1:0] sym_k_i,
    input  logic [SLOTS-1:0] sym_err_i,
    input  logic             sync_low_i,
    input  logic             fall_edge_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             de_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             link_ok_o,
    output logic             aux_valid_o,
    output logic [BYTE_W-1:0] aux_data_o
);
    word_kind_e kind;
    rx_view_t   stage_view;
    rx_view_t   out_view;

    rx_sym_classify u_classify (
        .lead_i (sym_data_i[BYTE_W-1:0]),
        .k_i    (sym_k_i),
        .err_i  (sym_err_i),
        .kind_o (kind)
    );

    rx_link_tracker #(.HS_LEN(HS_LEN)) u_tracker (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind_i (kind),
        .data_i (sym_data_i),
        .view_o (stage_view)
    );

    rx_out_stage u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall_edge_i),
        .view_i (stage_view),
        .view_o (out_view)
    );

    assign pix_o       = out_view.pix;
    assign de_o        = out_view.de;
    assign hsync_o     = out_view.hs_act ^ sync_low_i;
    assign vsync_o     = out_view.vs_act ^ sync_low_i;
    assign link_ok_o   = out_view.link_ok;
    assign aux_valid_o = out_view.aux_vld;
    assign aux_data_o  = out_view.aux;
endmodule

// File: rtl/rx_deframer_chk.sv
// Port-level properties of the receive deframer, bound to the top.
module rx_deframer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] sym_data_i,
    input logic [1:0]  sym_k_i,
    input logic [1:0]  sym_err_i,
    input logic        sync_low_i,
    input logic        de_o,
    input logic        hsync_o,
    input logic        vsync_o,
    input logic        link_ok_o,
    input logic        aux_valid_o
);
    logic line_word;
    assign line_word = (sym_k_i == 2'b01) && (sym_err_i == 2'b00) &&
                       (sym_data_i[7:0] == 8'hBC);

    assert_lock_on_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_word |=> link_ok_o);

    assert_drop_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sym_err_i != 2'b00) || sym_k_i[1]) |=> !link_ok_o);

    assert_quiet_when_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok_o |-> (!de_o && !aux_valid_o && hsync_o == sync_low_i && vsync_o == sync_low_i));

    assert_de_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> link_ok_o);

    assert_hsync_on_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_word |=> (hsync_o != sync_low_i));

    assert_aux_in_vblank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        aux_valid_o |-> (!de_o && link_ok_o && vsync_o != sync_low_i));
endmodule

bind rx_deframer rx_deframer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_data_i  (sym_data_i),
    .sym_k_i     (sym_k_i),
    .sym_err_i   (sym_err_i),
    .sync_low_i  (sync_low_i),
    .de_o        (de_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .link_ok_o   (link_ok_o),
    .aux_valid_o (aux_valid_o)
);

// File: tb/rx_deframer_tb.sv
module rx_deframer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sd_data = '0;
    logic [1:0]  sd_k = '0;
    logic [1:0]  sd_err = '0;
    logic        pol = 1'b0;
    logic        fall = 1'b0;
    logic [15:0] pix_o;
    logic        de_o, hsync_o, vsync_o, link_ok_o, aux_valid_o;
    logic [7:0]  aux_data_o;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    bit m_lock = 0, m_vs = 0;
    int m_left = 0;
    bit e_ok, e_de, e_hs, e_vs, e_av;
    logic [15:0] e_pix;
    logic [7:0]  e_ad;
    bit p_ok, p_de, p_hs;
    logic [15:0] p_pix;

    always #2.5 clk = ~clk;

    rx_deframer u_dut (
        .clk(clk), .rst_n(rst_n), .sym_data_i(sd_data), .sym_k_i(sd_k),
        .sym_err_i(sd_err), .sync_low_i(pol), .fall_edge_i(fall),
        .pix_o(pix_o), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .link_ok_o(link_ok_o), .aux_valid_o(aux_valid_o), .aux_data_o(aux_data_o)
    );

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model();
        bit bad, hs_now;
        logic [7:0] lead;
        lead = sd_data[7:0];
        p_ok = e_ok; p_de = e_de; p_hs = e_hs; p_pix = e_pix;
        e_de = 0; e_pix = '0; e_av = 0; e_ad = '0; hs_now = 0;
        if (!rst_n) begin
            m_lock = 0; m_vs = 0; m_left = 0;
        end else begin
            bad = (sd_err != 0) || sd_k[1] ||
                  (sd_k[0] && !(lead inside {8'hBC, 8'h1C, 8'hFB}));
            if (bad) begin
                m_lock = 0; m_vs = 0; m_left = 0;
            end else if (sd_k[0] && lead == 8'hBC) begin
                m_lock = 1; m_vs = sd_data[8]; m_left = 3; hs_now = 1;
            end else begin
                hs_now = (m_left > 0);
                if (m_left > 0) m_left--;
                if (m_lock) begin
                    if (!sd_k[0]) begin
                        e_de = 1; e_pix = sd_data;
                    end else if (lead == 8'hFB && m_vs) begin
                        e_av = 1; e_ad = sd_data[15:8];
                    end
                end
            end
        end
        e_ok = m_lock;
        e_hs = hs_now && m_lock;
        e_vs = m_vs && m_lock;
    endtask

    // One word: model it, then check early (edge mode) and late (all fields).
    task automatic step();
        model();
        @(posedge clk);
        #1.25;
        if (fall) begin
            chk("R9", "early de", de_o, p_de);
            chk("R9", "early pix", pix_o, p_pix);
            chk("R9", "early hsync", hsync_o, p_hs ^ pol);
        end else begin
            chk("R9", "early link", link_ok_o, e_ok);
            chk("R9", "early pix", pix_o, e_pix);
        end
        #2.5;
        chk("R2", "link_ok", link_ok_o, e_ok);
        chk("R4", "de", de_o, e_de);
        chk("R4", "pix", pix_o, e_pix);
        chk("R5", "hsync", hsync_o, e_hs ^ pol);
        chk("R6", "vsync", vsync_o, e_vs ^ pol);
        chk("R7", "aux_valid", aux_valid_o, e_av);
        chk("R7", "aux_data", aux_data_o, e_ad);
    endtask

    task automatic word(logic [15:0] d, logic [1:0] k, logic [1:0] e);
        sd_data = d; sd_k = k; sd_err = e;
        step();
    endtask
    task automatic line(bit vs);   word({7'd0, vs, 8'hBC}, 2'b01, 2'b00); endtask
    task automatic video(logic [15:0] p); word(p, 2'b00, 2'b00); endtask
    task automatic auxw(logic [7:0] b); word({b, 8'hFB}, 2'b01, 2'b00); endtask
    task automatic idle();         word(16'h001C, 2'b01, 2'b00); endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1.25;
        // R1: reset state
        for (int i = 0; i < 3; i++) video(16'hFFFF);
        chk("R1", "link after reset", link_ok_o, 0);
        chk("R1", "de after reset", de_o, 0);
        chk("R1", "hsync after reset", hsync_o, pol);
        chk("R1", "vsync after reset", vsync_o, pol);
        rst_n = 1'b1;
        // unlocked: video ignored
        video(16'h1234);
        chk("R3", "video while unlocked", de_o, 0);
        // lock, line with vertical low
        line(1'b0);
        chk("R2", "lock on line word", link_ok_o, 1);
        for (int i = 0; i < 6; i++) video(16'hA500 + 16'(i));
        idle();
        chk("R10", "idle de", de_o, 0);
        chk("R10", "idle pix", pix_o, 0);
        auxw(8'h5A);
        chk("R7", "aux outside vblank", aux_valid_o, 0);
        // vertical blanking: aux during hsync window
        line(1'b1);
        auxw(8'hC3);
        auxw(8'h3C);
        video(16'hBEEF);
        auxw(8'h81);
        // error inside hsync window
        line(1'b1);
        video(16'h0101);
        word(16'h0202, 2'b00, 2'b10);
        chk("R3", "error drops lock", link_ok_o, 0);
        video(16'h0303);
        auxw(8'h44);
        line(1'b0);
        video(16'h0404);
        word(16'h0055, 2'b01, 2'b00);
        chk("R3", "unknown control drops lock", link_ok_o, 0);
        idle();
        line(1'b0);
        word(16'h0606, 2'b10, 2'b00);
        video(16'h0707);
        // restart hsync window
        line(1'b0);
        video(16'h1111);
        line(1'b1);
        for (int i = 0; i < 5; i++) video(16'h2200 + 16'(i));
        // polarity active low
        pol = 1'b1;
        line(1'b0);
        chk("R8", "hsync active low", hsync_o, 0);
        chk("R8", "vsync inactive high", vsync_o, 1);
        for (int i = 0; i < 4; i++) video(16'h3300 + 16'(i));
        line(1'b1);
        auxw(8'h99);
        pol = 1'b0;
        video(16'h4444);
        // falling-edge output mode
        fall = 1'b1;
        line(1'b0);
        for (int i = 0; i < 5; i++) video(16'h5500 + 16'(i));
        line(1'b1);
        auxw(8'h77);
        word(16'h0808, 2'b00, 2'b01);
        video(16'h0909);
        line(1'b0);
        video(16'h6666);
        fall = 1'b0;
        video(16'h7777);
        idle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule